// File: doc/BRIEF.md
# Line-Granular Unified Cache Controller

This block is a set-associative, write-back, write-allocate cache that works on whole lines. An upper-level cache sends it line reads and line writes. It looks up the line, and on a miss it fetches the line from the next level down, writing back a dirty victim first. The same controller serves a mid-level cache and a last-level cache. The only difference between the two is the `NUM_SETS` and `LINE_W` parameters: 4 ways of 128 sets of 64-byte lines give 32 KB, and 32768 sets give 8 MB.

The downstream port keeps request acceptance (`dn_req_ready`) apart from data return (`dn_resp_valid`). Write-backs and fills are therefore each issued in one state and waited on in another. A write-back that is taken in the cycle it is first offered goes straight to the fill request.

After a refill the line is installed, and the controller looks up the tag again one cycle later. The request then completes through the normal hit path.

Top module: `ulc_cache`

Back-pressure rules:
- **Upstream requests.** A request is taken on a rising edge where `up_req_valid` and `up_req_ready` are both high. The requester holds the request until then.
- **Upstream responses.** `up_resp_valid` is a pulse that lasts one cycle and has no back-pressure. The requester must take it.
- **Downstream requests.** The controller holds `dn_req_valid` and all request fields steady until `dn_req_ready` is seen high on an edge.
- **Downstream responses.** `dn_resp_valid` is counted only while a fill is outstanding.

## Requirements
- R1: After reset, `up_req_ready` is 1, `up_resp_valid` is 0 and `dn_req_valid` is 0, and every way of every set is invalid, so the first access to any line misses.
- R2: `up_req_ready` is high only while the controller is idle. It drops in the cycle after a request is taken and comes back in the cycle that carries the response. No downstream request is presented while `up_req_ready` is high.
- R3: A read hit gives a one-cycle `up_resp_valid` pulse in the cycle after the acceptance edge. The pulse carries the stored line with `up_resp_error` 0, and no downstream request is made.
- R4: A write hit replaces the whole stored line with `up_req_wdata` and marks it dirty, with no downstream traffic. Its response, with the same timing as a read hit, echoes the written line.
- R5: A miss whose victim is clean presents a downstream read (`dn_req_write` 0) for the line address with the byte-offset bits zero. It waits for `dn_resp_valid`, installs the line clean, and delivers the response two cycles after the edge that samples the fill data.
- R6: A miss whose victim is valid and dirty first presents a downstream write (`dn_req_write` 1) carrying the victim's line address and contents. In the cycle after that write is accepted, the fill read is presented, whether the write was accepted at once or after waiting.
- R7: A write miss allocates the line through the same fill sequence, then overwrites it with `up_req_wdata`. Its response echoes the written line.
- R8: The victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the way named by a per-set counter. That counter starts at 0 and advances by one, modulo the way count, on every installed line.
- R9: A fill response with `dn_resp_error` 1 gives an upstream response with `up_resp_error` 1 on the same edge, and the line is not installed, so the next access to it misses again.
- R10: While `dn_req_valid` is high and `dn_req_ready` is low, `dn_req_valid`, `dn_req_write`, `dn_req_addr` and `dn_req_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_valid | input | 1 | Upstream request present |
| up_req_ready | output | 1 | Controller can take a request |
| up_req_write | input | 1 | 1 = line write, 0 = line read |
| up_req_addr | input | ADDR_W | Byte address of the line |
| up_req_wdata | input | LINE_W | Line data for writes |
| up_resp_valid | output | 1 | One-cycle response pulse |
| up_resp_error | output | 1 | Downstream error on the fill |
| up_resp_rdata | output | LINE_W | Read line, or written line for writes |
| dn_req_valid | output | 1 | Downstream request present |
| dn_req_ready | input | 1 | Downstream accepts the request this cycle |
| dn_req_write | output | 1 | 1 = write-back, 0 = fill read |
| dn_req_addr | output | ADDR_W | Line-aligned byte address |
| dn_req_wdata | output | LINE_W | Victim line for write-backs |
| dn_resp_valid | input | 1 | Fill data returned |
| dn_resp_error | input | 1 | Fill failed |
| dn_resp_rdata | input | LINE_W | Fill line data |

## Verification
Each result has a fixed due cycle:
- **Hits.** A hit response is due exactly one cycle after the edge that takes the request.
- **Successful misses.** The response is due two cycles after the edge that samples the fill data, one cycle for the install and one for the re-compare.
- **Errored fills.** The error response appears on the sampling edge itself.

The driver stamps each expected item with its acceptance cycle and the kind of result due. The downstream model records the edge on which it handed over fill data. The monitor compares the response cycle against the stamp that belongs to its kind. The downstream model also checks that a fill read follows one cycle after every accepted write-back, and that request fields stay steady across every stalled cycle.

// File: rtl/ulc_pkg.sv
package ulc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_WB_ISSUE,
    ST_WB_HOLD,
    ST_FILL_ISSUE,
    ST_FILL_HOLD,
    ST_INSTALL
  } ulc_state_e;

endpackage

// File: rtl/ulc_tag_store.sv
module ulc_tag_store #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 22,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [IDX_W-1:0]                 rd_set,
  output logic [NUM_WAYS-1:0]              rd_valid,
  output logic [NUM_WAYS-1:0]              rd_dirty,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]   rd_tag,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_set,
  input  logic [WAY_W-1:0]                 wr_way,
  input  logic                             wr_valid,
  input  logic                             wr_dirty,
  input  logic [TAG_W-1:0]                 wr_tag
);

  // One entry per way and set: tag plus valid and dirty flags.
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [NUM_SETS-1:0] vld_q;
    logic [NUM_SETS-1:0] drt_q;
    logic [TAG_W-1:0]    tag_q [NUM_SETS];
    logic                sel;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (sel) begin
        vld_q[wr_set] <= wr_valid;
        drt_q[wr_set] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) tag_q[wr_set] <= wr_tag;
    end

    assign rd_valid[w] = vld_q[rd_set];
    assign rd_dirty[w] = drt_q[rd_set];
    assign rd_tag[w]   = tag_q[rd_set];
  end

endmodule

// File: rtl/ulc_data_store.sv
module ulc_data_store #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int LINE_W   = 512,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int DEPTH   = NUM_SETS * NUM_WAYS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [LINE_W-1:0] wr_line
);

  logic [LINE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{wr_set, wr_way}] <= wr_line;
  end

  assign rd_line = mem_q[{rd_set, rd_way}];

endmodule

// File: rtl/ulc_victim_sel.sv
module ulc_victim_sel #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic [NUM_WAYS-1:0] set_valid,
  output logic [WAY_W-1:0]    victim_way,
  input  logic                advance
);

  logic [WAY_W-1:0] ctr_q [NUM_SETS];
  logic [WAY_W-1:0] ctr_cur;

  assign ctr_cur = ctr_q[set_idx];

  // Lowest invalid way wins; otherwise the round counter names the way.
  always_comb begin
    victim_way = ctr_cur;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) victim_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) ctr_q[s] <= '0;
    end else if (advance) begin
      ctr_q[set_idx] <= (ctr_cur == WAY_W'(NUM_WAYS - 1)) ? '0 : ctr_cur + WAY_W'(1);
    end
  end

endmodule

// File: rtl/ulc_cache.sv
module ulc_cache
  import ulc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_W   = 512,
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic              up_req_write,
  input  logic [ADDR_W-1:0] up_req_addr,
  input  logic [LINE_W-1:0] up_req_wdata,
  output logic              up_resp_valid,
  output logic              up_resp_error,
  output logic [LINE_W-1:0] up_resp_rdata,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic [LINE_W-1:0] dn_req_wdata,
  input  logic              dn_resp_valid,
  input  logic              dn_resp_error,
  input  logic [LINE_W-1:0] dn_resp_rdata
);

  localparam int OFF_W = $clog2(LINE_W / 8);
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  ulc_state_e state_q, state_d;

  logic              req_write_q;
  logic [TAG_W-1:0]  req_tag_q;
  logic [IDX_W-1:0]  req_idx_q;
  logic [LINE_W-1:0] req_wdata_q;
  logic [WAY_W-1:0]  victim_q;
  logic [TAG_W-1:0]  victim_tag_q;
  logic [LINE_W-1:0] fill_q;
  logic              resp_valid_q, resp_err_q;
  logic [LINE_W-1:0] resp_data_q;

  logic [NUM_WAYS-1:0]            way_valid, way_dirty, hit_vec;
  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag;
  logic                           hit;
  logic [WAY_W-1:0]               hit_way, victim_way, rd_way, tag_wr_way;
  logic [LINE_W-1:0]              rd_line;

  logic              tag_we, tag_wdirty, data_we, ctr_adv;
  logic [LINE_W-1:0] data_wline;
  logic              resp_set, resp_err;
  logic [LINE_W-1:0] resp_line;

  // Lookup against the captured request.
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag_q);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    hit = |hit_vec;
  end

  assign rd_way     = (state_q == ST_COMPARE) ? hit_way : victim_q;
  assign tag_wr_way = (state_q == ST_INSTALL) ? victim_q : hit_way;

  ulc_tag_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (req_idx_q),
    .rd_valid (way_valid),
    .rd_dirty (way_dirty),
    .rd_tag   (way_tag),
    .wr_en    (tag_we),
    .wr_set   (req_idx_q),
    .wr_way   (tag_wr_way),
    .wr_valid (1'b1),
    .wr_dirty (tag_wdirty),
    .wr_tag   (req_tag_q)
  );

  ulc_data_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .rd_set  (req_idx_q),
    .rd_way  (rd_way),
    .rd_line (rd_line),
    .wr_en   (data_we),
    .wr_set  (req_idx_q),
    .wr_way  (tag_wr_way),
    .wr_line (data_wline)
  );

  ulc_victim_sel #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_idx    (req_idx_q),
    .set_valid  (way_valid),
    .victim_way (victim_way),
    .advance    (ctr_adv)
  );

  // Next state and write strobes.
  always_comb begin
    state_d    = state_q;
    tag_we     = 1'b0;
    tag_wdirty = 1'b0;
    data_we    = 1'b0;
    data_wline = fill_q;
    ctr_adv    = 1'b0;
    resp_set   = 1'b0;
    resp_err   = 1'b0;
    resp_line  = rd_line;
    unique case (state_q)
      ST_IDLE: if (up_req_valid) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (hit) begin
          resp_set = 1'b1;
          state_d  = ST_IDLE;
          if (req_write_q) begin
            tag_we     = 1'b1;
            tag_wdirty = 1'b1;
            data_we    = 1'b1;
            data_wline = req_wdata_q;
            resp_line  = req_wdata_q;
          end
        end else if (way_valid[victim_way] && way_dirty[victim_way]) begin
          state_d = ST_WB_ISSUE;
        end else begin
          state_d = ST_FILL_ISSUE;
        end
      end
      ST_WB_ISSUE:   state_d = dn_req_ready ? ST_FILL_ISSUE : ST_WB_HOLD;
      ST_WB_HOLD:    if (dn_req_ready) state_d = ST_FILL_ISSUE;
      ST_FILL_ISSUE: if (dn_req_ready) state_d = ST_FILL_HOLD;
      ST_FILL_HOLD: begin
        if (dn_resp_valid) begin
          if (dn_resp_error) begin
            resp_set  = 1'b1;
            resp_err  = 1'b1;
            resp_line = '0;
            state_d   = ST_IDLE;
          end else begin
            state_d = ST_INSTALL;
          end
        end
      end
      ST_INSTALL: begin
        tag_we  = 1'b1;
        data_we = 1'b1;
        ctr_adv = 1'b1;
        state_d = ST_COMPARE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      resp_valid_q <= 1'b0;
      resp_err_q   <= 1'b0;
    end else begin
      state_q      <= state_d;
      resp_valid_q <= resp_set;
      if (resp_set) resp_err_q <= resp_err;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && up_req_valid) begin
      req_write_q <= up_req_write;
      req_tag_q   <= up_req_addr[ADDR_W-1 -: TAG_W];
      req_idx_q   <= up_req_addr[OFF_W +: IDX_W];
      req_wdata_q <= up_req_wdata;
    end
    if (state_q == ST_COMPARE && !hit) begin
      victim_q     <= victim_way;
      victim_tag_q <= way_tag[victim_way];
    end
    if (state_q == ST_FILL_HOLD && dn_resp_valid) fill_q <= dn_resp_rdata;
    if (resp_set) resp_data_q <= resp_line;
  end

  assign up_req_ready  = (state_q == ST_IDLE);
  assign up_resp_valid = resp_valid_q;
  assign up_resp_error = resp_err_q;
  assign up_resp_rdata = resp_data_q;

  assign dn_req_valid = (state_q == ST_WB_ISSUE) || (state_q == ST_WB_HOLD) ||
                        (state_q == ST_FILL_ISSUE);
  assign dn_req_write = (state_q == ST_WB_ISSUE) || (state_q == ST_WB_HOLD);
  assign dn_req_addr  = dn_req_write ? {victim_tag_q, req_idx_q, {OFF_W{1'b0}}}
                                     : {req_tag_q, req_idx_q, {OFF_W{1'b0}}};
  assign dn_req_wdata = rd_line;

endmodule

// File: rtl/ulc_cache_chk.sv
module ulc_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req_valid,
  input logic              up_req_ready,
  input logic              up_resp_valid,
  input logic              dn_req_valid,
  input logic              dn_req_ready,
  input logic              dn_req_write,
  input logic [ADDR_W-1:0] dn_req_addr,
  input logic [LINE_W-1:0] dn_req_wdata
);

  localparam int OFF_W = $clog2(LINE_W / 8);

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_valid && up_req_ready |=> !up_req_ready);

  p_no_dn_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_ready |-> !dn_req_valid);

  p_resp_back_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    up_resp_valid |-> up_req_ready);

  p_resp_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up_resp_valid |=> !up_resp_valid);

  p_dn_line_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> (dn_req_addr[OFF_W-1:0] == '0));

  p_fill_after_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && dn_req_ready && dn_req_write |=> dn_req_valid && !dn_req_write);

  p_dn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_write) &&
      $stable(dn_req_addr) && $stable(dn_req_wdata));

endmodule

bind ulc_cache ulc_cache_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .up_req_valid  (up_req_valid),
  .up_req_ready  (up_req_ready),
  .up_resp_valid (up_resp_valid),
  .dn_req_valid  (dn_req_valid),
  .dn_req_ready  (dn_req_ready),
  .dn_req_write  (dn_req_write),
  .dn_req_addr   (dn_req_addr),
  .dn_req_wdata  (dn_req_wdata)
);

// File: tb/tb_ulc_cache.sv
`timescale 1ns/1ps
module tb_ulc_cache;

  localparam int K_HIT  = 0;
  localparam int K_MISS = 1;
  localparam int K_ERR  = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up_req_valid = 1'b0, up_req_write = 1'b0;
  logic [31:0]  up_req_addr = '0;
  logic [511:0] up_req_wdata = '0;
  logic         up_req_ready, up_resp_valid, up_resp_error;
  logic [511:0] up_resp_rdata;
  logic         dn_req_valid, dn_req_write;
  logic [31:0]  dn_req_addr;
  logic [511:0] dn_req_wdata;
  logic         dn_req_ready = 1'b0, dn_resp_valid = 1'b0, dn_resp_error = 1'b0;
  logic [511:0] dn_resp_rdata = '0;

  always #2.5 clk = ~clk;

  ulc_cache dut (.*);

  typedef struct {
    logic [511:0] data;
    bit           err;
    int           kind;
    int           acc;
  } exp_t;

  exp_t         sb[$];
  logic [511:0] gold[logic [31:0]];
  logic [511:0] mem[logic [31:0]];
  int n_tests = 0, n_fail = 0, cyc = 0;
  int ready_delay = 2, resp_lat = 3, last_fill_cyc = 0;
  int rd_count = 0, wb_count = 0;
  logic [31:0]  last_wb_addr = '0, err_addr = '0;
  logic [511:0] last_wb_data = '0;
  bit err_en = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [511:0] init_line(input logic [31:0] a);
    return {16{a ^ 32'hC3C3_0000}};
  endfunction

  task automatic check_eq(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Downstream model: programmable accept delay and fill latency.
  initial begin : dn_model
    int wait_cnt, fill_cnt;
    bit pend_fill, wb_flag;
    logic [31:0] fill_addr, held_addr;
    logic held_wr;
    wait_cnt = 0; fill_cnt = 0; pend_fill = 0; wb_flag = 0;
    fill_addr = '0; held_addr = '0; held_wr = 0;
    forever begin
      @(negedge clk);
      dn_req_ready  = 1'b0;
      dn_resp_valid = 1'b0;
      dn_resp_error = 1'b0;
      if (wb_flag) begin
        wb_flag = 0;
        check_eq("R6 fill read follows accepted write-back",
                 {510'd0, dn_req_valid, dn_req_write}, 512'd2);
      end
      if (pend_fill) begin
        if (fill_cnt == 0) begin
          pend_fill     = 0;
          dn_resp_valid = 1'b1;
          dn_resp_error = err_en && (fill_addr == err_addr);
          dn_resp_rdata = mem.exists(fill_addr) ? mem[fill_addr] : init_line(fill_addr);
          last_fill_cyc = cyc + 1;
        end else begin
          fill_cnt--;
        end
      end else if (rst_n && dn_req_valid) begin
        if (wait_cnt > 0) begin
          check_eq("R10 stalled request address held", dn_req_addr, held_addr);
          check_eq("R10 stalled request kind held", dn_req_write, held_wr);
        end
        if (wait_cnt >= ready_delay) begin
          dn_req_ready = 1'b1;
          wait_cnt = 0;
          if (dn_req_write) begin
            mem[dn_req_addr] = dn_req_wdata;
            wb_count++;
            last_wb_addr = dn_req_addr;
            last_wb_data = dn_req_wdata;
            wb_flag = 1;
          end else begin
            rd_count++;
            pend_fill = 1;
            fill_cnt  = resp_lat;
            fill_addr = dn_req_addr;
          end
        end else begin
          held_addr = dn_req_addr;
          held_wr   = dn_req_write;
          wait_cnt++;
        end
      end
    end
  end

  // Monitor: pops expected items as responses appear.
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (up_resp_valid) begin
        if (sb.size() == 0) begin
          check_eq("R2 unexpected upstream response", 512'd1, 512'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check_eq("R9 response error flag", {511'd0, up_resp_error}, {511'd0, e.err});
          if (!e.err) check_eq("R3/R4/R5/R7 response line", up_resp_rdata, e.data);
          if (e.kind == K_HIT)
            check_eq("R3 hit due one cycle after accept", cyc, e.acc + 1);
          else if (e.kind == K_MISS)
            check_eq("R5 miss due two cycles after fill", cyc, last_fill_cyc + 2);
          else
            check_eq("R9 error due on fill edge", cyc, last_fill_cyc);
        end
      end
    end
  end

  // Driver: pushes the expected item and waits for the monitor to consume it.
  task automatic do_req(input bit wr, input logic [31:0] a, input logic [511:0] d, input int kind);
    exp_t e;
    @(negedge clk);
    up_req_valid = 1'b1;
    up_req_write = wr;
    up_req_addr  = a;
    up_req_wdata = d;
    while (!up_req_ready) @(negedge clk);
    e.err  = (kind == K_ERR);
    e.kind = kind;
    e.acc  = cyc + 1;
    if (wr) begin
      e.data = d;
      if (kind != K_ERR) gold[a] = d;
    end else begin
      e.data = gold.exists(a) ? gold[a] : init_line(a);
    end
    sb.push_back(e);
    @(negedge clk);
    up_req_valid = 1'b0;
    check_eq("R2 ready low after accept", {511'd0, up_req_ready}, 512'd0);
    while (sb.size() != 0) @(negedge clk);
  endtask

  function automatic logic [31:0] a0(input int k);
    return 32'(k) << 10;
  endfunction

  localparam logic [31:0]  B_ADDR = 32'h0000_00C0;
  localparam logic [31:0]  C_ADDR = 32'h0000_0140;
  localparam logic [511:0] W0 = {16{32'h1111_0000}};
  localparam logic [511:0] W1 = {16{32'h2222_0001}};
  localparam logic [511:0] W2 = {16{32'h3333_0002}};

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    check_eq("R1 ready during reset", {511'd0, up_req_ready}, 512'd1);
    check_eq("R1 no response in reset", {511'd0, up_resp_valid}, 512'd0);
    check_eq("R1 no downstream request in reset", {511'd0, dn_req_valid}, 512'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R5: empty cache misses; clean fill.
    do_req(0, a0(0), '0, K_MISS);
    check_eq("R5 one fill read", rd_count, 1);
    // R3: read hit.
    do_req(0, a0(0), '0, K_HIT);
    check_eq("R3 no downstream on hit", rd_count, 1);
    // R4: write hit, then read back.
    do_req(1, a0(0), W0, K_HIT);
    check_eq("R4 no write-back on write hit", wb_count, 0);
    do_req(0, a0(0), '0, K_HIT);
    // R7: write miss allocates then overwrites.
    do_req(1, B_ADDR, W1, K_MISS);
    check_eq("R7 write miss fetched line", rd_count, 2);
    do_req(0, B_ADDR, '0, K_HIT);
    // Fill the remaining ways of set 0.
    do_req(0, a0(1), '0, K_MISS);
    do_req(0, a0(2), '0, K_MISS);
    do_req(0, a0(3), '0, K_MISS);
    check_eq("R8 empty ways filled without eviction", wb_count, 0);
    // R6: dirty victim (way 0) accepted at once.
    ready_delay = 0;
    do_req(0, a0(4), '0, K_MISS);
    check_eq("R6 one write-back", wb_count, 1);
    check_eq("R6 write-back address", last_wb_addr, a0(0));
    check_eq("R6 write-back data", last_wb_data, W0);
    // R8: counter moved on; way 1 still holds line 1.
    do_req(0, a0(1), '0, K_HIT);
    check_eq("R8 survivor hit", rd_count, 6);
    do_req(1, a0(2), W2, K_HIT);
    do_req(0, a0(0), '0, K_MISS);
    check_eq("R8 clean victim no write-back", wb_count, 1);
    // R6: dirty victim (way 2) with delayed acceptance.
    ready_delay = 3;
    do_req(0, a0(1), '0, K_MISS);
    check_eq("R6 delayed write-back count", wb_count, 2);
    check_eq("R6 delayed write-back address", last_wb_addr, a0(2));
    check_eq("R6 delayed write-back data", last_wb_data, W2);
    do_req(0, a0(2), '0, K_MISS);
    do_req(0, a0(4), '0, K_HIT);
    check_eq("R8 counter order kept line 4", rd_count, 9);
    // R9: errored fill is reported and not installed.
    ready_delay = 1;
    err_en = 1;
    err_addr = C_ADDR;
    do_req(0, C_ADDR, '0, K_ERR);
    err_en = 0;
    do_req(0, C_ADDR, '0, K_MISS);
    check_eq("R9 line refetched after error", rd_count, 11);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule